// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a command register interface and a flash macro. Each accepted command becomes a series of primitive flash operations. The macro can only program one write word at a time, and it can erase either one page or the whole program space of a panel in a single operation. Three program commands are supported.

A single write programs one write word. A quad write programs four consecutive write words. Both take their data from holding registers. A row write programs the four write words of a row, and it fetches each word from system SRAM before programming it. It reads that data one SRAM beat at a time over a valid/ready stream that may stall.

The two erase commands each issue one primitive. The sequencer checks that the start address matches the size of the operation. It reports busy, a one-cycle done pulse and a one-cycle error pulse, and it counts the write words that the macro has acknowledged.

Top module: `flash_seq`

## Requirements
- R1: Opcode 0 (single write) issues exactly one primitive with fl_kind 0 (program) at cmd_addr. Its data is holding word 0, which is hold_data bits WW-1:0.
- R2: Opcode 1 (quad write) issues four program primitives, one after another, at cmd_addr, cmd_addr+WW/8, cmd_addr+2*WW/8 and cmd_addr+3*WW/8. Their data is holding words 0, 1, 2 and 3, where word i is hold_data[i*WW +: WW].
- R3: Opcode 2 (row write) issues four program primitives at consecutive write-word addresses. Before each one, the block fetches WW/BW beats from SRAM. The first beat is read at cmd_src, each later beat is read BW/8 bytes higher, and the first beat of a word fills its least significant bits.
- R4: A beat is taken only in a cycle where sram_vld and sram_rdy are both high. sram_rdy is high only while a fetch is in progress, and a stall does not corrupt the data.
- R5: Opcode 3 (page erase) issues a single primitive with fl_kind 1 at cmd_addr.
- R6: Opcode 4 (panel erase) issues a single primitive with fl_kind 2 at cmd_addr.
- R7: The start address must be aligned to WW/8 bytes for a single write, to 4*WW/8 bytes for a quad or row write, and to 16*WW/8 bytes for either erase. A misaligned command pulses err in the next cycle, leaves busy low and issues no primitive.
- R8: busy rises in the cycle after a command is accepted. It falls in the same cycle as done, and done is a single-cycle pulse that follows the acknowledge of the last primitive.
- R9: A command that arrives while busy is high pulses err and is dropped. The operation already running continues unchanged.
- R10: words_done is cleared when a command is accepted. It counts each program primitive that the macro acknowledges, so an erase leaves it at 0.
- R11: While fl_req is high and fl_ack has not yet arrived, fl_req, fl_kind, fl_addr and fl_wdata all hold their values.
- R12: Opcodes 5 to 7 are illegal. They pulse err and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Flash start address (bytes) |
| cmd_src | input | AW | SRAM source address for a row write |
| hold_data | input | 4*WW | Holding words; word i is at [i*WW +: WW] |
| sram_vld | input | 1 | SRAM beat valid |
| sram_data | input | BW | SRAM beat data |
| sram_rdy | output | 1 | Sequencer ready for a beat |
| sram_addr | output | AW | Address of the beat being requested |
| fl_req | output | 1 | Primitive request to the flash macro |
| fl_kind | output | 2 | 0 program, 1 page erase, 2 panel erase |
| fl_addr | output | AW | Primitive address |
| fl_wdata | output | WW | Write word for a program primitive |
| fl_ack | input | 1 | Primitive complete, one cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Command rejected pulse |
| words_done | output | $clog2(4+1) | Write words acknowledged for the current command |

## Verification
The assertions assume that the macro raises fl_ack only while fl_req is high and holds it for one cycle. They also assume that hold_data stays constant while a quad or single write is busy. The bench's flash model acknowledges each request once, after a delay that varies from one to three cycles, and then drops fl_ack on the next cycle. The holding words change only between commands. The SRAM model stalls sram_vld on a fixed repeating pattern and keeps its data tied to sram_addr.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   typedef enum logic [2:0] {
      OP_SINGLE    = 3'd0,
      OP_QUAD      = 3'd1,
      OP_ROW       = 3'd2,
      OP_PG_ERASE  = 3'd3,
      OP_PNL_ERASE = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      FK_PROG      = 2'd0,
      FK_PG_ERASE  = 2'd1,
      FK_PNL_ERASE = 2'd2
   } fkind_e;

   typedef enum logic [1:0] {
      S_IDLE, S_FETCH, S_PROG, S_ERASE
   } st_e;
endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
   import flash_seq_pkg::*;
#(
   parameter int AW  = 24,
   parameter int WW  = 64,
   parameter int WPR = 4,
   parameter int RPP = 4
) (
   input  logic [2:0]               op,
   input  logic [AW-1:0]            addr,
   output logic                     legal,
   output logic                     aligned,
   output logic                     is_row,
   output logic                     is_erase,
   output fkind_e                   kind,
   output logic [$clog2(WPR)-1:0]   last_idx
);
   localparam int WB_LG   = $clog2(WW/8);
   localparam int ROW_LG  = WB_LG + $clog2(WPR);
   localparam int PAGE_LG = ROW_LG + $clog2(RPP);
   localparam logic [AW-1:0] WORD_MSK = AW'((64'd1 << WB_LG) - 64'd1);
   localparam logic [AW-1:0] ROW_MSK  = AW'((64'd1 << ROW_LG) - 64'd1);
   localparam logic [AW-1:0] PAGE_MSK = AW'((64'd1 << PAGE_LG) - 64'd1);

   logic [AW-1:0] msk;

   always_comb begin
      legal    = 1'b1;
      is_row   = 1'b0;
      is_erase = 1'b0;
      kind     = FK_PROG;
      last_idx = '0;
      msk      = WORD_MSK;
      case (op)
         OP_SINGLE:    msk = WORD_MSK;
         OP_QUAD:      begin msk = ROW_MSK; last_idx = '1; end
         OP_ROW:       begin msk = ROW_MSK; last_idx = '1; is_row = 1'b1; end
         OP_PG_ERASE:  begin msk = PAGE_MSK; is_erase = 1'b1; kind = FK_PG_ERASE; end
         OP_PNL_ERASE: begin msk = PAGE_MSK; is_erase = 1'b1; kind = FK_PNL_ERASE; end
         default:      legal = 1'b0;
      endcase
      aligned = ((addr & msk) == '0);
   end
endmodule

// File: rtl/flash_seq_fetch.sv
module flash_seq_fetch #(
   parameter int AW = 24,
   parameter int WW = 64,
   parameter int BW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] base,
   input  logic          sram_vld,
   input  logic [BW-1:0] sram_data,
   output logic          sram_rdy,
   output logic [AW-1:0] sram_addr,
   output logic          word_done,
   output logic [WW-1:0] word
);
   localparam int BEATS = WW / BW;
   localparam int BB    = BW / 8;

   assign sram_rdy = en;

   generate
      if (BEATS == 1) begin : g_one_beat
         assign sram_addr = base;
         assign word_done = en && sram_vld;
         assign word      = sram_data;
      end else begin : g_multi_beat
         localparam int BCW = $clog2(BEATS);
         logic [BCW-1:0]    beat;
         logic [WW-BW-1:0]  part;
         logic              last;

         assign last      = (beat == BCW'(BEATS-1));
         assign sram_addr = base + AW'(beat) * AW'(BB);
         assign word_done = en && sram_vld && last;
         assign word      = {sram_data, part};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               beat <= '0;
               part <= '0;
            end else if (en && sram_vld) begin
               if (last) begin
                  beat <= '0;
               end else begin
                  part[beat*BW +: BW] <= sram_data;
                  beat <= beat + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_seq_pkg::*;
#(
   parameter int AW  = 24,
   parameter int WW  = 64,
   parameter int BW  = 32,
   parameter int WPR = 4,
   parameter int RPP = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [2:0]                 cmd_op,
   input  logic [AW-1:0]              cmd_addr,
   input  logic [AW-1:0]              cmd_src,
   input  logic [WPR*WW-1:0]          hold_data,
   input  logic                       sram_vld,
   input  logic [BW-1:0]              sram_data,
   output logic                       sram_rdy,
   output logic [AW-1:0]              sram_addr,
   output logic                       fl_req,
   output logic [1:0]                 fl_kind,
   output logic [AW-1:0]              fl_addr,
   output logic [WW-1:0]              fl_wdata,
   input  logic                       fl_ack,
   output logic                       busy,
   output logic                       done,
   output logic                       err,
   output logic [$clog2(WPR+1)-1:0]   words_done
);
   localparam int IW = $clog2(WPR);
   localparam int CW = $clog2(WPR+1);
   localparam logic [AW-1:0] WB = AW'(WW/8);

   if (WW % BW != 0 || BW % 8 != 0) begin : g_bad_width
      $error("flash_seq: WW must be a multiple of BW, BW a multiple of 8");
   end
   if (WPR < 2 || (WPR & (WPR-1)) != 0 || (RPP & (RPP-1)) != 0) begin : g_bad_geom
      $error("flash_seq: WPR and RPP must be powers of two, WPR >= 2");
   end

   st_e            st;
   fkind_e         kind_q;
   logic           row_q;
   logic [AW-1:0]  addr_q, src_q;
   logic [IW-1:0]  idx, last_q, nxt_idx;
   logic [WW-1:0]  wdata, hold_sel, f_word;

   logic           d_legal, d_aligned, d_row, d_erase, f_done;
   fkind_e         d_kind;
   logic [IW-1:0]  d_last;

   flash_seq_decode #(.AW(AW), .WW(WW), .WPR(WPR), .RPP(RPP)) u_dec (
      .op(cmd_op), .addr(cmd_addr), .legal(d_legal), .aligned(d_aligned),
      .is_row(d_row), .is_erase(d_erase), .kind(d_kind), .last_idx(d_last)
   );

   flash_seq_fetch #(.AW(AW), .WW(WW), .BW(BW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .en(st == S_FETCH), .base(src_q),
      .sram_vld(sram_vld), .sram_data(sram_data), .sram_rdy(sram_rdy),
      .sram_addr(sram_addr), .word_done(f_done), .word(f_word)
   );

   assign nxt_idx = idx + 1'b1;

   always_comb begin
      hold_sel = '0;
      for (int i = 0; i < WPR; i++)
         if (IW'(i) == nxt_idx) hold_sel = hold_data[i*WW +: WW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         kind_q     <= FK_PROG;
         row_q      <= 1'b0;
         addr_q     <= '0;
         src_q      <= '0;
         idx        <= '0;
         last_q     <= '0;
         wdata      <= '0;
         words_done <= '0;
         done       <= 1'b0;
         err        <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (st != S_IDLE && cmd_valid) err <= 1'b1;
         case (st)
            S_IDLE: if (cmd_valid) begin
               if (!d_legal || !d_aligned) begin
                  err <= 1'b1;
               end else begin
                  addr_q     <= cmd_addr;
                  src_q      <= cmd_src;
                  idx        <= '0;
                  last_q     <= d_last;
                  kind_q     <= d_kind;
                  row_q      <= d_row;
                  words_done <= '0;
                  wdata      <= hold_data[WW-1:0];
                  st         <= d_erase ? S_ERASE : (d_row ? S_FETCH : S_PROG);
               end
            end
            S_FETCH: if (f_done) begin
               wdata <= f_word;
               src_q <= src_q + WB;
               st    <= S_PROG;
            end
            S_PROG: if (fl_ack) begin
               words_done <= words_done + CW'(1);
               if (idx == last_q) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  idx    <= nxt_idx;
                  addr_q <= addr_q + WB;
                  if (row_q) st <= S_FETCH;
                  else       wdata <= hold_sel;
               end
            end
            S_ERASE: if (fl_ack) begin
               done <= 1'b1;
               st   <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy     = (st != S_IDLE);
   assign fl_req   = (st == S_PROG) || (st == S_ERASE);
   assign fl_kind  = kind_q;
   assign fl_addr  = addr_q;
   assign fl_wdata = wdata;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
   parameter int AW = 24,
   parameter int WW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          fl_req,
   input logic          fl_ack,
   input logic [1:0]    fl_kind,
   input logic [AW-1:0] fl_addr,
   input logic [WW-1:0] fl_wdata,
   input logic          sram_rdy
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_kind) && $stable(fl_addr) && $stable(fl_wdata)); // R11
   AST_RDY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      sram_rdy |-> busy && !fl_req); // R4
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(fl_req && fl_ack)); // R8
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
   AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !err); // R7
   AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> busy); // R8
endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .WW(WW)) u_chk (.*);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
   localparam int AW = 24, WW = 64, BW = 32, WPR = 4;
   localparam int WB = WW/8;

   typedef struct packed {
      logic [1:0]    kind;
      logic [AW-1:0] addr;
      logic [WW-1:0] data;
   } prim_t;

   logic clk = 0, rst_n = 0;
   logic cmd_valid = 0;
   logic [2:0] cmd_op = 0;
   logic [AW-1:0] cmd_addr = 0, cmd_src = 0;
   logic [WPR*WW-1:0] hold_data = 0;
   logic sram_vld = 0;
   logic [BW-1:0] sram_data = 0;
   logic sram_rdy, fl_req, busy, done, err;
   logic [AW-1:0] sram_addr, fl_addr;
   logic [1:0] fl_kind;
   logic [WW-1:0] fl_wdata;
   logic fl_ack = 0;
   logic [2:0] words_done;

   int checks = 0, errors = 0, cyc = 0, lat = 1, cnt = 0;
   prim_t expq[$];

   flash_seq u_flash_seq (.*);

   always #2.5 clk = ~clk;

   function automatic logic [BW-1:0] mem(logic [AW-1:0] a);
      return {8'h5A, a} ^ 32'h00F0_0F0F;
   endfunction

   task automatic check(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // SRAM model with stalls; flash model + scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      sram_vld  = (cyc % 3) != 0;
      sram_data = mem(sram_addr);
      if (fl_ack) begin
         fl_ack = 0;
         cnt = 0;
      end else if (fl_req) begin
         if (cnt >= lat) begin
            prim_t e;
            fl_ack = 1;
            if (expq.size() == 0) begin
               check(0, "R9", "unexpected primitive addr", WW'(fl_addr), 0);
            end else begin
               e = expq.pop_front();
               check(fl_kind == e.kind, "R1-kind", "primitive kind", WW'(fl_kind), WW'(e.kind));
               check(fl_addr == e.addr, "R2", "primitive address", WW'(fl_addr), WW'(e.addr));
               check(fl_wdata == e.data || e.kind != 2'd0, "R3", "program data", fl_wdata, e.data);
            end
         end else cnt++;
      end
      if (cyc > 150000) begin
         check(0, "R8", "watchdog expired", 0, 0);
         finish_run();
      end
   end

   task automatic start(logic [2:0] op, logic [AW-1:0] a, logic [AW-1:0] s);
      @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_src = s;
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic expect_prog(int n, logic [AW-1:0] a, bit row, logic [AW-1:0] s);
      for (int k = 0; k < n; k++) begin
         prim_t e;
         e.kind = 2'd0;
         e.addr = a + AW'(k*WB);
         if (row) e.data = {mem(s + AW'(k*WB + 4)), mem(s + AW'(k*WB))};
         else     e.data = hold_data[k*WW +: WW];
         expq.push_back(e);
      end
   endtask

   task automatic wait_done(string req, int exp_words);
      int t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check(done, req, "done pulse seen", WW'(done), 1);
      check(!busy, "R8", "busy low with done", WW'(busy), 0);
      check(words_done == 3'(exp_words), "R10", "words_done", WW'(words_done), WW'(exp_words));
      @(negedge clk);
      check(!done, "R8", "done one cycle", WW'(done), 0);
      check(expq.size() == 0, req, "all primitives issued", WW'(expq.size()), 0);
   endtask

   task automatic expect_reject(string req);
      check(err, req, "err pulse", WW'(err), 1);
      check(!busy, req, "busy stays low", WW'(busy), 0);
      check(!fl_req, req, "no primitive", WW'(fl_req), 0);
      @(negedge clk);
      check(!err && !busy && !fl_req, req, "still idle", WW'({err, busy, fl_req}), 0);
   endtask

   initial begin
      for (int i = 0; i < WPR; i++) hold_data[i*WW +: WW] = {32'hC0DE0000 + i, 32'h1111_1111 * (i+1)};
      repeat (3) @(negedge clk);
      check(!busy && !done && !err && !fl_req && !sram_rdy, "R8", "reset state",
            WW'({busy, done, err, fl_req, sram_rdy}), 0);
      rst_n = 1;

      // R1 single write
      lat = 1;
      expect_prog(1, 24'h000108, 0, 0);
      start(3'd0, 24'h000108, 0);
      check(busy, "R8", "busy after accept", WW'(busy), 1);
      wait_done("R1", 1);

      // R2 quad write
      lat = 3;
      hold_data[WW +: WW] = 64'hFEED_0000_BEEF_0001;
      expect_prog(4, 24'h000220, 0, 0);
      start(3'd1, 24'h000220, 0);
      wait_done("R2", 4);

      // R3/R4 row write with SRAM stalls
      lat = 2;
      expect_prog(4, 24'h000400, 1, 24'h003010);
      start(3'd2, 24'h000400, 24'h003010);
      wait_done("R3", 4);
      check(!sram_rdy, "R4", "rdy low when idle", WW'(sram_rdy), 0);

      // R5 page erase
      lat = 1;
      expq.push_back('{kind: 2'd1, addr: 24'h000800, data: '0});
      start(3'd3, 24'h000800, 0);
      wait_done("R5", 0);

      // R6 panel erase
      expq.push_back('{kind: 2'd2, addr: 24'h000000, data: '0});
      start(3'd4, 24'h000000, 0);
      wait_done("R6", 0);

      // R7 misalignment
      start(3'd0, 24'h000104, 0); expect_reject("R7");
      start(3'd1, 24'h000208, 0); expect_reject("R7");
      start(3'd2, 24'h000410, 0); expect_reject("R7");
      start(3'd3, 24'h000840, 0); expect_reject("R7");

      // R12 illegal opcodes
      start(3'd5, 24'h000000, 0); expect_reject("R12");
      start(3'd7, 24'h000000, 0); expect_reject("R12");

      // R9 command while busy
      lat = 3;
      expect_prog(4, 24'h000a00, 0, 0);
      start(3'd1, 24'h000a00, 0);
      start(3'd3, 24'h001000, 0);
      check(err, "R9", "err on busy command", WW'(err), 1);
      check(busy, "R9", "operation continues", WW'(busy), 1);
      wait_done("R9", 4);

      // back-to-back row write after quad, different source
      lat = 1;
      expect_prog(4, 24'h000c20, 1, 24'h000100);
      start(3'd2, 24'h000c20, 24'h000100);
      wait_done("R3", 4);

      repeat (5) @(negedge clk);
      check(expq.size() == 0 && !fl_req, "R9", "no extra primitives", WW'(fl_req), 0);
      finish_run();
   end
endmodule